// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the serial shift engine of an SPI master. Software-visible fields arrive as plain inputs: an enable, clock polarity and phase, bit order, chip-select index, active-low select polarity, a discard-receive flag, manual select control, and two 24-bit byte counts. One count is the total length of the burst. The other says how many of those bytes come from the transmit FIFO. A one-cycle `go_set` pulse raises the start bit. The engine then clocks out 8-bit words at the rate set by the `edge_tick` strobes from an external divider. It pops transmit bytes while the transmit count lasts, then sends zero filler. It pushes each received byte into the receive FIFO unless discard is set.

The controller is a six-state machine:
- `ST_IDLE` waits for the start bit with enable high. It goes to `ST_PREP`, or to `ST_FINISH` when the burst length is zero.
- `ST_PREP` is the byte boundary. It stalls here while the byte it needs is missing or the receive FIFO has no room. Otherwise it loads the shifter and moves to `ST_LEAD`.
- `ST_LEAD` holds SCLK at its idle level. A tick moves it to `ST_TRAIL`.
- `ST_TRAIL` holds SCLK at the opposite level. A tick returns it to `ST_LEAD`, or after the eighth bit moves it to `ST_BYTE_END`.
- `ST_BYTE_END` pushes the received byte. It then moves to `ST_PREP`, or to `ST_FINISH` after the last byte.
- `ST_FINISH` pulses completion, clears the start bit and returns to `ST_IDLE`.

Four chip-select pins are driven. In automatic mode the selected pin is active from `ST_PREP` through the last `ST_BYTE_END`. In manual mode the selected pin follows a level bit. Either way, unselected pins sit at the inactive level implied by the polarity bit.

Top module: `spi_xfer_engine`

## Requirements
- R1: A `go_set` pulse sets `go_bit`. No SCLK edge occurs while `cfg_en` is low; `go_bit` stays pending, and the burst runs once `cfg_en` rises.
- R2: With `cfg_cpha`=0 and `cfg_lsb_first`=0, MOSI carries each byte MSB first. The bit is valid before the leading SCLK edge, MISO is sampled on that edge, and each received byte is pushed on `rxf_data` in order.
- R3: While idle, SCLK equals `cfg_cpol`. With `cfg_cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Each byte takes exactly 16 SCLK edges.
- R4: With `cfg_lsb_first`=1, bit 0 of each byte is sent first, and the first received bit lands in bit 0.
- R5: The first min(`tx_len`,`burst_len`) bytes are popped from the transmit FIFO in order. Every later byte of the burst is sent as 0x00 without a pop.
- R6: With `tx_len`=0, the burst pops nothing, sends 0x00 bytes and still receives every byte.
- R7: While `cfg_discard_rx` is 1, `rxf_push` never rises.
- R8: After the last byte, `done_pulse` is high for exactly one cycle, then `go_bit` reads 0 and SCLK is idle.
- R9: In automatic mode (`cfg_cs_manual`=0), pin `cfg_cs_sel` is at its active level (low when `cfg_cs_act_low`=1) on every sampling edge of the burst. It returns to inactive after completion. At most one pin is ever active.
- R10: In manual mode, pin `cfg_cs_sel` equals `cfg_cs_level`, and every other pin equals `cfg_cs_act_low`.
- R11: If a byte still needs transmit data and `txf_empty` is 1, the engine waits at the byte boundary with no SCLK edge and no pop. It resumes once data arrives.
- R12: If received data is kept and `rxf_full` is 1, the engine waits at the byte boundary with no SCLK edge and no push. It resumes once space frees.
- R13: A burst with `burst_len`=0 completes with `done_pulse` and no SCLK edge and no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Engine enable; gates the start of a burst |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cs_act_low | input | 1 | 1: selects are active low; also sets idle level of unselected pins |
| cfg_lsb_first | input | 1 | 1: bit 0 shifted first |
| cfg_cs_sel | input | 2 | Index of the chip-select pin in use |
| cfg_discard_rx | input | 1 | 1: received bytes are dropped |
| cfg_cs_manual | input | 1 | 1: selected pin follows `cfg_cs_level` |
| cfg_cs_level | input | 1 | Manual level of the selected pin |
| burst_len | input | 24 | Total bytes in the burst |
| tx_len | input | 24 | Bytes of the burst taken from the transmit FIFO |
| go_set | input | 1 | One-cycle pulse that sets the start bit |
| go_bit | output | 1 | Start bit; clears itself when the burst completes |
| done_pulse | output | 1 | One-cycle completion strobe |
| txf_empty | input | 1 | Transmit FIFO has no data |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Consume the transmit FIFO head |
| rxf_full | input | 1 | Receive FIFO has no room |
| rxf_push | output | 1 | Write `rxf_data` to the receive FIFO |
| rxf_data | output | 8 | Received byte |
| edge_tick | input | 1 | Half-period strobe from the clock divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pins | output | 4 | Chip-select pins |

## Verification
The bench drives a slave model on the serial pins. It rebuilds every MOSI byte on the edge the configured phase makes the sampling edge, and returns a known MISO pattern in the configured bit order.

The bench targets these corner cases:
- Partial filler bursts. A design that kept popping past the transmit count would drain the FIFO, and one that sent stale data instead of zeros would show the wrong MOSI bytes.
- Receive-only and discard transfers. A design that popped or pushed anyway would fail the FIFO counts.
- Stalls on an empty transmit FIFO and a full receive FIFO. A design that clocked regardless would show SCLK edges during the wait and garbage bytes afterwards.
- Mode 3 with LSB-first order and the zero-length burst. These catch bit reversal mistakes, phase swaps, and a machine that hangs or clocks one byte when the length is zero.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_LEAD,
        ST_TRAIL,
        ST_BYTE_END,
        ST_FINISH
    } xfer_state_t;

endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          lsb_first,
    input  logic          cpha,
    input  logic          lead_edge,
    input  logic          trail_edge,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_byte
);

    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;
    logic [DW-1:0] load_rev;
    logic [DW-1:0] rx_rev;
    logic          launch;
    logic          sample;

    for (genvar gi = 0; gi < DW; gi++) begin : g_rev
        assign load_rev[gi] = load_data[DW-1-gi];
        assign rx_rev[gi]   = rx_sr[DW-1-gi];
    end

    // Phase 0 launches at load and trailing edges; phase 1 at leading edges.
    assign launch = cpha ? lead_edge : trail_edge;
    assign sample = cpha ? trail_edge : lead_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            mosi  <= 1'b0;
        end else begin
            if (load) begin
                if (!cpha) begin
                    {mosi, tx_sr} <= {(lsb_first ? load_rev : load_data), 1'b0};
                end else begin
                    tx_sr <= lsb_first ? load_rev : load_data;
                end
            end else if (launch) begin
                {mosi, tx_sr} <= {tx_sr, 1'b0};
            end
            if (sample) begin
                rx_sr <= {rx_sr[DW-2:0], miso};
            end
        end
    end

    always_comb begin
        rx_byte = lsb_first ? rx_rev : rx_sr;
    end

endmodule

// File: rtl/spi_cs_ctrl.sv
`timescale 1ns/1ps
module spi_cs_ctrl #(
    parameter int NCS  = 4,
    parameter int SELW = 2
) (
    input  logic [SELW-1:0] sel,
    input  logic            act_low,
    input  logic            manual,
    input  logic            man_level,
    input  logic            active,
    output logic [NCS-1:0]  cs_pins
);

    for (genvar gi = 0; gi < NCS; gi++) begin : g_pin
        // Unselected pins always rest at the inactive level.
        assign cs_pins[gi] = (sel == SELW'(gi))
                           ? (manual ? man_level : (active ^ act_low))
                           : act_low;
    end

endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine #(
    parameter int DW   = 8,
    parameter int CW   = 24,
    parameter int NCS  = 4,
    localparam int SELW = $clog2(NCS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_cpha,
    input  logic            cfg_cpol,
    input  logic            cfg_cs_act_low,
    input  logic            cfg_lsb_first,
    input  logic [SELW-1:0] cfg_cs_sel,
    input  logic            cfg_discard_rx,
    input  logic            cfg_cs_manual,
    input  logic            cfg_cs_level,
    input  logic [CW-1:0]   burst_len,
    input  logic [CW-1:0]   tx_len,
    input  logic            go_set,
    output logic            go_bit,
    output logic            done_pulse,
    input  logic            txf_empty,
    input  logic [DW-1:0]   txf_data,
    output logic            txf_pop,
    input  logic            rxf_full,
    output logic            rxf_push,
    output logic [DW-1:0]   rxf_data,
    input  logic            edge_tick,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NCS-1:0]  cs_pins
);
    import spi_xfer_pkg::*;

    localparam int BCW = $clog2(DW);

    xfer_state_t    state, state_nx;
    logic [CW-1:0]  bytes_left;
    logic [CW-1:0]  tx_left;
    logic [BCW-1:0] bit_idx;
    logic           need_tx, prep_go, lead_edge, trail_edge, last_bit;
    logic           xfer_active, start_ok;
    logic [DW-1:0]  load_byte;
    logic [DW-1:0]  rx_byte;

    always_comb begin
        need_tx    = (tx_left != '0);
        start_ok   = go_bit && cfg_en;
        prep_go    = (state == ST_PREP)
                   && !(need_tx && txf_empty)
                   && !(!cfg_discard_rx && rxf_full);
        lead_edge  = (state == ST_LEAD) && edge_tick;
        trail_edge = (state == ST_TRAIL) && edge_tick;
        last_bit   = (bit_idx == BCW'(DW-1));
        load_byte  = need_tx ? txf_data : '0;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_ok) state_nx = (burst_len == '0) ? ST_FINISH : ST_PREP;
            ST_PREP:     if (prep_go) state_nx = ST_LEAD;
            ST_LEAD:     if (edge_tick) state_nx = ST_TRAIL;
            ST_TRAIL:    if (edge_tick) state_nx = last_bit ? ST_BYTE_END : ST_LEAD;
            ST_BYTE_END: state_nx = (bytes_left == CW'(1)) ? ST_FINISH : ST_PREP;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_left <= '0;
            tx_left    <= '0;
            bit_idx    <= '0;
            go_bit     <= 1'b0;
        end else begin
            if (go_set)                  go_bit <= 1'b1;
            else if (state == ST_FINISH) go_bit <= 1'b0;

            if (state == ST_IDLE && start_ok) begin
                bytes_left <= burst_len;
                tx_left    <= tx_len;
                bit_idx    <= '0;
            end
            if (prep_go && need_tx)      tx_left <= tx_left - CW'(1);
            if (trail_edge)              bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
            if (state == ST_BYTE_END)    bytes_left <= bytes_left - CW'(1);
        end
    end

    always_comb begin
        txf_pop     = prep_go && need_tx;
        rxf_push    = (state == ST_BYTE_END) && !cfg_discard_rx;
        done_pulse  = (state == ST_FINISH);
        sclk        = cfg_cpol ^ (state == ST_TRAIL);
        xfer_active = (state == ST_PREP) || (state == ST_LEAD)
                   || (state == ST_TRAIL) || (state == ST_BYTE_END);
    end

    assign rxf_data = rx_byte;

    spi_byte_shifter #(.DW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (prep_go),
        .load_data  (load_byte),
        .lsb_first  (cfg_lsb_first),
        .cpha       (cfg_cpha),
        .lead_edge  (lead_edge),
        .trail_edge (trail_edge),
        .miso       (miso),
        .mosi       (mosi),
        .rx_byte    (rx_byte)
    );

    spi_cs_ctrl #(.NCS(NCS), .SELW(SELW)) u_cs (
        .sel       (cfg_cs_sel),
        .act_low   (cfg_cs_act_low),
        .manual    (cfg_cs_manual),
        .man_level (cfg_cs_level),
        .active    (xfer_active),
        .cs_pins   (cs_pins)
    );

endmodule

// File: rtl/spi_xfer_engine_sva.sv
`timescale 1ns/1ps
module spi_xfer_engine_sva #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           go_set,
    input logic           go_bit,
    input logic           done_pulse,
    input logic           sclk,
    input logic           cfg_cpol,
    input logic           txf_pop,
    input logic           txf_empty,
    input logic           rxf_push,
    input logic           rxf_full,
    input logic           cfg_discard_rx,
    input logic           cfg_cs_act_low,
    input logic [NCS-1:0] cs_pins
);

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !go_bit |-> (sclk == cfg_cpol));

    p_go_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && !go_set) |=> !go_bit);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    p_pop_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txf_pop |-> !txf_empty);

    p_push_guard_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push |-> !rxf_full);

    p_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_discard_rx |-> !rxf_push);

    p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_pins ^ {NCS{cfg_cs_act_low}}));

endmodule

bind spi_xfer_engine spi_xfer_engine_sva #(.NCS(NCS)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .go_set         (go_set),
    .go_bit         (go_bit),
    .done_pulse     (done_pulse),
    .sclk           (sclk),
    .cfg_cpol       (cfg_cpol),
    .txf_pop        (txf_pop),
    .txf_empty      (txf_empty),
    .rxf_push       (rxf_push),
    .rxf_full       (rxf_full),
    .cfg_discard_rx (cfg_discard_rx),
    .cfg_cs_act_low (cfg_cs_act_low),
    .cs_pins        (cs_pins)
);

// File: tb/spi_xfer_engine_test.sv
`timescale 1ns/1ps
module spi_xfer_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1, cfg_cpha = 1'b0, cfg_cpol = 1'b0;
    logic        cfg_cs_act_low = 1'b1, cfg_lsb = 1'b0;
    logic [1:0]  cfg_cs_sel = 2'd2;
    logic        cfg_discard = 1'b0, cfg_cs_manual = 1'b0, cfg_cs_level = 1'b0;
    logic [23:0] burst_len = '0, tx_len = '0;
    logic        go_set = 1'b0;
    logic        go_bit, done_pulse, txf_empty, txf_pop, rxf_push, sclk, mosi, miso;
    logic [7:0]  txf_data, rxf_data;
    logic        rx_block = 1'b0;
    logic        edge_tick = 1'b0;
    logic [3:0]  cs_pins;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpha(cfg_cpha),
        .cfg_cpol(cfg_cpol), .cfg_cs_act_low(cfg_cs_act_low),
        .cfg_lsb_first(cfg_lsb), .cfg_cs_sel(cfg_cs_sel),
        .cfg_discard_rx(cfg_discard), .cfg_cs_manual(cfg_cs_manual),
        .cfg_cs_level(cfg_cs_level), .burst_len(burst_len), .tx_len(tx_len),
        .go_set(go_set), .go_bit(go_bit), .done_pulse(done_pulse),
        .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
        .rxf_full(rx_block), .rxf_push(rxf_push), .rxf_data(rxf_data),
        .edge_tick(edge_tick), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_pins(cs_pins)
    );

    // FIFO models
    logic [7:0] txq [64];
    logic [7:0] rxq [64];
    int tx_wr = 0, tx_rd = 0, rx_wr = 0;
    assign txf_empty = (tx_wr == tx_rd);
    assign txf_data  = txq[tx_rd % 64];
    always @(posedge clk) begin
        if (txf_pop) tx_rd <= tx_rd + 1;
        if (rxf_push) begin
            rxq[rx_wr % 64] <= rxf_data;
            rx_wr <= rx_wr + 1;
        end
    end

    // Divider strobe: one tick every three cycles
    int tcnt = 0;
    always @(posedge clk) begin
        if (tcnt == 2) begin tcnt <= 0; edge_tick <= 1'b1; end
        else begin tcnt <= tcnt + 1; edge_tick <= 1'b0; end
    end

    function automatic logic [7:0] sl_byte(input int k);
        return 8'h3C ^ 8'(k * 37);
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Slave model and monitor, evaluated at the falling edge
    logic       prev_sclk = 1'b0, lead;
    int         edge_cnt = 0, cap_cnt = 0, mon_byte = 0, done_cnt = 0, cs_bad = 0;
    logic [2:0] mon_bit = '0;
    logic [7:0] acc = '0;
    logic [7:0] capq [64];
    logic [3:0] exp_cs = 4'b1011;
    logic [7:0] sl_cur;
    assign sl_cur = sl_byte(mon_byte);
    assign miso = cfg_lsb ? sl_cur[mon_bit] : sl_cur[3'd7 - mon_bit];

    always @(negedge clk) begin
        if (done_pulse) done_cnt++;
        if (go_bit && sclk != prev_sclk) begin
            edge_cnt++;
            lead = (sclk != cfg_cpol);
            if (lead != cfg_cpha) begin
                if (cs_pins != exp_cs) cs_bad++;
                acc = {acc[6:0], mosi};
                if (mon_bit == 3'd7) begin
                    capq[cap_cnt % 64] = cfg_lsb ? rev8(acc) : acc;
                    cap_cnt++;
                    mon_byte++;
                end
                mon_bit++;
            end
        end
        prev_sclk = sclk;
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    int b_cap, b_rx, b_rd, b_edges, b_done, b_byte;

    task automatic push_tx(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            txq[tx_wr % 64] = seed + 8'(i * 8'h53);
            tx_wr++;
        end
    endtask

    task automatic launch(input int nb, input int nt);
        step();
        burst_len = 24'(nb); tx_len = 24'(nt);
        b_cap = cap_cnt; b_rx = rx_wr; b_rd = tx_rd;
        b_edges = edge_cnt; b_done = done_cnt; b_byte = mon_byte;
        go_set = 1'b1;
        step();
        go_set = 1'b0;
    endtask

    task automatic wait_done(input string rq);
        int n = 0;
        while (done_cnt == b_done && n < 20000) begin step(); n++; end
        chk(rq, "completion seen", int'(done_cnt != b_done), 1);
        step(); step();
        chk("R8", "single done pulse", done_cnt - b_done, 1);
        chk("R8", "start bit cleared", go_bit, 0);
        chk("R8", "sclk idle after", sclk, cfg_cpol);
    endtask

    task automatic check_xfer(input string rq, input int nb, input int nt,
                              input logic [7:0] seed, input bit disc);
        int np = (nt < nb) ? nt : nb;
        for (int i = 0; i < nb; i++) begin
            logic [7:0] e = (i < nt) ? seed + 8'(i * 8'h53) : 8'h00;
            chk(rq, "mosi byte", capq[(b_cap + i) % 64], e);
        end
        chk(rq, "pops", tx_rd - b_rd, np);
        chk(rq, "sclk edges", edge_cnt - b_edges, 16 * nb);
        if (disc) chk(rq, "pushes", rx_wr - b_rx, 0);
        else begin
            chk(rq, "pushes", rx_wr - b_rx, nb);
            for (int i = 0; i < nb; i++)
                chk(rq, "rx byte", rxq[(b_rx + i) % 64], sl_byte(b_byte + i));
        end
    endtask

    task automatic t_reset();
        chk("R3", "reset sclk", sclk, 0);
        chk("R9", "reset cs", cs_pins, 4'hF);
        chk("R1", "reset go_bit", go_bit, 0);
        chk("R8", "reset done", done_pulse, 0);
    endtask

    task automatic t_basic();
        int bad0 = cs_bad;
        push_tx(3, 8'hA5);
        launch(3, 3);
        wait_done("R2");
        check_xfer("R2", 3, 3, 8'hA5, 0);
        chk("R9", "auto cs active on samples", cs_bad - bad0, 0);
        chk("R9", "cs released", cs_pins, 4'hF);
    endtask

    task automatic t_filler();
        push_tx(2, 8'h19);
        launch(4, 2);
        wait_done("R5");
        check_xfer("R5", 4, 2, 8'h19, 0);
    endtask

    task automatic t_rx_only();
        launch(2, 0);
        wait_done("R6");
        check_xfer("R6", 2, 0, 8'h00, 0);
    endtask

    task automatic t_discard();
        cfg_discard = 1'b1;
        push_tx(2, 8'hC3);
        launch(2, 2);
        wait_done("R7");
        check_xfer("R7", 2, 2, 8'hC3, 1);
        cfg_discard = 1'b0;
    endtask

    task automatic t_mode3_lsb();
        step();
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lsb = 1'b1;
        step();
        chk("R3", "idle sclk high", sclk, 1);
        push_tx(2, 8'h61);
        launch(2, 2);
        wait_done("R3");
        check_xfer("R4", 2, 2, 8'h61, 0);
        step();
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb = 1'b0;
    endtask

    task automatic t_manual_cs();
        step();
        cfg_cs_manual = 1'b1; cfg_cs_sel = 2'd1; cfg_cs_level = 1'b0;
        step(); chk("R10", "manual low", cs_pins, 4'b1101);
        cfg_cs_level = 1'b1;
        step(); chk("R10", "manual high", cs_pins, 4'b1111);
        cfg_cs_act_low = 1'b0;
        step(); chk("R10", "manual high, idle low", cs_pins, 4'b0010);
        cfg_cs_level = 1'b0;
        step(); chk("R10", "manual low, idle low", cs_pins, 4'b0000);
        cfg_cs_manual = 1'b0; cfg_cs_act_low = 1'b1; cfg_cs_sel = 2'd2;
        step();
    endtask

    task automatic t_tx_stall();
        launch(1, 1);
        repeat (40) step();
        chk("R11", "no edges while empty", edge_cnt - b_edges, 0);
        chk("R11", "no pop while empty", tx_rd - b_rd, 0);
        chk("R11", "still pending", go_bit, 1);
        push_tx(1, 8'h5A);
        wait_done("R11");
        check_xfer("R11", 1, 1, 8'h5A, 0);
    endtask

    task automatic t_rx_stall();
        rx_block = 1'b1;
        push_tx(1, 8'h77);
        launch(1, 1);
        repeat (40) step();
        chk("R12", "no edges while full", edge_cnt - b_edges, 0);
        chk("R12", "no push while full", rx_wr - b_rx, 0);
        rx_block = 1'b0;
        wait_done("R12");
        check_xfer("R12", 1, 1, 8'h77, 0);
    endtask

    task automatic t_enable();
        cfg_en = 1'b0;
        push_tx(1, 8'hE1);
        launch(1, 1);
        repeat (40) step();
        chk("R1", "no edges while disabled", edge_cnt - b_edges, 0);
        chk("R1", "start pending", go_bit, 1);
        cfg_en = 1'b1;
        wait_done("R1");
        check_xfer("R1", 1, 1, 8'hE1, 0);
    endtask

    task automatic t_zero();
        launch(0, 0);
        wait_done("R13");
        chk("R13", "no edges", edge_cnt - b_edges, 0);
        chk("R13", "no pops", tx_rd - b_rd, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_filler();
        t_rx_only();
        t_discard();
        t_mode3_lsb();
        t_manual_cs();
        t_tx_stall();
        t_rx_stall();
        t_enable();
        t_zero();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule